// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block drives a parallel RGB panel from a faster controller clock. A programmable divider derives the pixel clock. A horizontal counter and a vertical counter walk the raster and produce the line sync, the frame sync, a data-enable window and the active pixel coordinates. A one-cycle request strobe marks each active pixel period, so that a pixel FIFO upstream can be popped at the rate the panel consumes data.

All timing values arrive on configuration inputs. They are captured into a shadow copy while the block is idle and at every frame boundary, so software may rewrite them at any moment without tearing a frame. The configuration covers the divider value, the pixel-clock launch edge, the polarity of each sync, a dual-scan mode, and the four segment lengths of each axis. The horizontal segments are counted in pixel periods and the vertical segments in lines.

Top module: `lcd_timing_gen`

## Requirements
- R1: With divider value N (8 bits, 0..255), one pixel-clock period lasts 2·(N+1) controller clocks. The pixel clock is high for N+1 clocks and low for N+1 clocks.
- R2: Each line is a sequence of sync pulse (hsw periods), lead-in (hbp), active (hact) and trail (hfp). The line length is their sum. A segment of length zero is skipped. hsync is asserted only during the sync segment.
- R3: Each frame uses the same sequence counted in whole lines: vsw, vbp, the active line count, then vfp. vsync changes only at a line start.
- R4: de_o is high only when both axes are in their active segment. During active periods pix_x_o and pix_y_o give the 0-based active column and row. They read 0 outside the active window.
- R5: pix_req_o pulses high for exactly one controller clock in every pixel period where de_o is high, in the first clock after the outputs update. It is low in all other clocks.
- R6: A polarity bit of 1 makes the corresponding sync active-high. A polarity bit of 0 makes it active-low. The two bits are independent.
- R7: When cfg_dual_i is 1, the number of active lines is the frame line count divided by two, rounded down. When cfg_dual_i is 0, the full count is used.
- R8: When cfg_launch_rise_i is 0, outputs change on the falling edge of pclk_o and pclk_o idles low. When it is 1, pclk_o is inverted, so outputs change on its rising edge and it idles high.
- R9: A configuration write during a frame does not affect that frame. It takes effect from the first pixel of the next frame.
- R10: While en_i is low, or during reset, the counters are held, de_o and pix_req_o are 0, the syncs sit at their inactive level and pclk_o sits at its idle level. All of this applies one clock after en_i falls. After enable, the first launch edge begins pixel (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable |
| cfg_pcd_i | input | PCD_W | Pixel clock divider value N |
| cfg_launch_rise_i | input | 1 | Launch data on rising pclk_o edge |
| cfg_hs_high_i | input | 1 | hsync active-high when 1 |
| cfg_vs_high_i | input | 1 | vsync active-high when 1 |
| cfg_dual_i | input | 1 | Dual-scan: halve the active line count |
| cfg_hsw_i | input | H_W | hsync width in pixel periods |
| cfg_hbp_i | input | H_W | Line lead-in in pixel periods |
| cfg_hact_i | input | H_W | Active pixels per line |
| cfg_hfp_i | input | H_W | Line trail in pixel periods |
| cfg_vsw_i | input | V_W | vsync width in lines |
| cfg_vbp_i | input | V_W | Frame lead-in in lines |
| cfg_vlines_i | input | V_W | Frame height in lines |
| cfg_vfp_i | input | V_W | Frame trail in lines |
| pclk_o | output | 1 | Pixel clock to the panel |
| hsync_o | output | 1 | Line sync |
| vsync_o | output | 1 | Frame sync |
| de_o | output | 1 | Data enable |
| pix_req_o | output | 1 | One-clock pixel request strobe |
| pix_x_o | output | H_W | Active column |
| pix_y_o | output | V_W | Active row |

## Verification
The bench walks every pixel period of two full frames for a set of small configurations and compares all outputs against a raster computed from the segment lengths. The configurations include zero-length porches and a zero-length sync. A counter that ignored a zero segment would shift the active window by one period, and the comparison would catch it. The divider is exercised at 0, 1, 2 and 255, where an off-by-one would show up as a wrong clock count between launch edges. The odd frame height in dual-scan mode would expose a halving that rounds up. A mid-frame rewrite that also changes the divider would reveal shadow registers that load early, because the rest of the current frame would tear. Finally, disabling the block in the middle of a frame checks that no sync remains stuck at its active level.

// File: rtl/lcd_tg_pkg.sv
`timescale 1ns/1ps
package lcd_tg_pkg;

    // Which pixel-clock edge launches panel data
    typedef enum logic {
        LAUNCH_FALL = 1'b0,
        LAUNCH_RISE = 1'b1
    } launch_e;

    // Segment membership of one axis position
    typedef struct packed {
        logic sync;
        logic active;
    } seg_flags_t;

    // Map a logical "asserted" to a pin level for a given polarity
    function automatic logic pin_level(input logic asserted, input logic act_high);
        return act_high ? asserted : ~asserted;
    endfunction

endpackage

// File: rtl/lcd_tg_pixdiv.sv
`timescale 1ns/1ps
module lcd_tg_pixdiv #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half_m1,
    output logic             pclk,
    output logic             adv
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             lvl;
    } div_s;

    div_s div_q, div_d;
    logic at_end;

    always_comb begin
        div_d  = div_q;
        at_end = (div_q.cnt >= half_m1);
        adv    = en && at_end && div_q.lvl;
        if (!en) begin
            div_d = '0;
        end else if (at_end) begin
            div_d.cnt = '0;
            div_d.lvl = ~div_q.lvl;
        end else begin
            div_d.cnt = div_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign pclk = div_q.lvl;

    // R1: the clock level only moves when a half period is complete
    assert_pclk_half_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && div_q.cnt < half_m1) |=> $stable(pclk));

    // R10: a disabled divider parks the clock low
    assert_pclk_park_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pclk);

endmodule

// File: rtl/lcd_tg_axis.sv
`timescale 1ns/1ps
module lcd_tg_axis
    import lcd_tg_pkg::*;
#(
    parameter int unsigned SEG_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             step,
    input  logic [SEG_W-1:0] cur_sync,
    input  logic [SEG_W-1:0] cur_lead,
    input  logic [SEG_W-1:0] cur_act,
    input  logic [SEG_W-1:0] cur_trail,
    input  logic [SEG_W-1:0] nxt_sync,
    input  logic [SEG_W-1:0] nxt_lead,
    input  logic [SEG_W-1:0] nxt_act,
    output logic             wrap,
    output seg_flags_t       flags,
    output logic [SEG_W-1:0] idx
);

    localparam int unsigned POS_W = SEG_W + 2;

    typedef struct packed {
        logic [POS_W-1:0] pos;
        seg_flags_t       flg;
        logic [SEG_W-1:0] idx;
    } axis_s;

    axis_s            ax_q, ax_d;
    logic [POS_W-1:0] span;
    logic [POS_W-1:0] act_lo;
    logic [POS_W-1:0] act_hi;

    // Wrap uses only the configuration in force for the running frame
    always_comb begin
        span = POS_W'(cur_sync) + POS_W'(cur_lead) + POS_W'(cur_act) + POS_W'(cur_trail);
        wrap = step && (ax_q.pos == span - POS_W'(1));
    end

    always_comb begin
        ax_d = ax_q;
        if (hold || wrap)  ax_d.pos = '0;
        else if (step)     ax_d.pos = ax_q.pos + POS_W'(1);
        act_lo = POS_W'(nxt_sync) + POS_W'(nxt_lead);
        act_hi = act_lo + POS_W'(nxt_act);
        ax_d.flg.sync   = ax_d.pos < POS_W'(nxt_sync);
        ax_d.flg.active = (ax_d.pos >= act_lo) && (ax_d.pos < act_hi);
        ax_d.idx        = ax_d.flg.active ? SEG_W'(ax_d.pos - act_lo) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ax_q <= '0;
        else        ax_q <= ax_d;
    end

    assign flags = ax_q.flg;
    assign idx   = ax_q.idx;

    // R2 / R3: sync and active segments never overlap
    assert_seg_disjoint_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flags.active |-> !flags.sync);

    // R3: position stays inside the programmed span
    assert_pos_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (span != '0) |-> (ax_q.pos < span));

endmodule

// File: rtl/lcd_timing_gen.sv
`timescale 1ns/1ps
module lcd_timing_gen
    import lcd_tg_pkg::*;
#(
    parameter int unsigned PCD_W = 8,
    parameter int unsigned H_W   = 10,
    parameter int unsigned V_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [PCD_W-1:0] cfg_pcd_i,
    input  logic             cfg_launch_rise_i,
    input  logic             cfg_hs_high_i,
    input  logic             cfg_vs_high_i,
    input  logic             cfg_dual_i,
    input  logic [H_W-1:0]   cfg_hsw_i,
    input  logic [H_W-1:0]   cfg_hbp_i,
    input  logic [H_W-1:0]   cfg_hact_i,
    input  logic [H_W-1:0]   cfg_hfp_i,
    input  logic [V_W-1:0]   cfg_vsw_i,
    input  logic [V_W-1:0]   cfg_vbp_i,
    input  logic [V_W-1:0]   cfg_vlines_i,
    input  logic [V_W-1:0]   cfg_vfp_i,
    output logic             pclk_o,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic             pix_req_o,
    output logic [H_W-1:0]   pix_x_o,
    output logic [V_W-1:0]   pix_y_o
);

    typedef struct packed {
        logic [PCD_W-1:0] pcd;
        launch_e          launch;
        logic             hs_high;
        logic             vs_high;
        logic [H_W-1:0]   hsw;
        logic [H_W-1:0]   hbp;
        logic [H_W-1:0]   hact;
        logic [H_W-1:0]   hfp;
        logic [V_W-1:0]   vsw;
        logic [V_W-1:0]   vbp;
        logic [V_W-1:0]   vact;
        logic [V_W-1:0]   vfp;
    } shadow_s;

    typedef struct packed {
        shadow_s shd;
        logic    run;
        logic    adv_seen;
    } top_s;

    top_s       st_q, st_d;
    shadow_s    shd_d;
    logic       adv, pclk_raw;
    logic       h_wrap, v_wrap;
    seg_flags_t h_flags, v_flags;
    logic [H_W-1:0] h_idx;
    logic [V_W-1:0] v_idx;

    lcd_tg_pixdiv #(.DIV_W(PCD_W)) div_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_i),
        .half_m1 (st_q.shd.pcd),
        .pclk    (pclk_raw),
        .adv     (adv)
    );

    // Shadow capture: while idle, and on the last step of a frame
    always_comb begin
        shd_d = st_q.shd;
        if (!st_q.run || v_wrap) begin
            shd_d.pcd     = cfg_pcd_i;
            shd_d.launch  = launch_e'(cfg_launch_rise_i);
            shd_d.hs_high = cfg_hs_high_i;
            shd_d.vs_high = cfg_vs_high_i;
            shd_d.hsw     = cfg_hsw_i;
            shd_d.hbp     = cfg_hbp_i;
            shd_d.hact    = cfg_hact_i;
            shd_d.hfp     = cfg_hfp_i;
            shd_d.vsw     = cfg_vsw_i;
            shd_d.vbp     = cfg_vbp_i;
            shd_d.vact    = cfg_dual_i ? (cfg_vlines_i >> 1) : cfg_vlines_i;
            shd_d.vfp     = cfg_vfp_i;
        end
    end

    always_comb begin
        st_d          = st_q;
        st_d.shd      = shd_d;
        st_d.run      = en_i && (st_q.run || adv);
        st_d.adv_seen = adv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    lcd_tg_axis #(.SEG_W(H_W)) h_axis_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (!en_i),
        .step      (adv && st_q.run),
        .cur_sync  (st_q.shd.hsw),
        .cur_lead  (st_q.shd.hbp),
        .cur_act   (st_q.shd.hact),
        .cur_trail (st_q.shd.hfp),
        .nxt_sync  (shd_d.hsw),
        .nxt_lead  (shd_d.hbp),
        .nxt_act   (shd_d.hact),
        .wrap      (h_wrap),
        .flags     (h_flags),
        .idx       (h_idx)
    );

    lcd_tg_axis #(.SEG_W(V_W)) v_axis_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (!en_i),
        .step      (h_wrap),
        .cur_sync  (st_q.shd.vsw),
        .cur_lead  (st_q.shd.vbp),
        .cur_act   (st_q.shd.vact),
        .cur_trail (st_q.shd.vfp),
        .nxt_sync  (shd_d.vsw),
        .nxt_lead  (shd_d.vbp),
        .nxt_act   (shd_d.vact),
        .wrap      (v_wrap),
        .flags     (v_flags),
        .idx       (v_idx)
    );

    assign pclk_o    = (st_q.shd.launch == LAUNCH_RISE) ? ~pclk_raw : pclk_raw;
    assign hsync_o   = pin_level(st_q.run && h_flags.sync, st_q.shd.hs_high);
    assign vsync_o   = pin_level(st_q.run && v_flags.sync, st_q.shd.vs_high);
    assign de_o      = st_q.run && h_flags.active && v_flags.active;
    assign pix_req_o = de_o && st_q.adv_seen;
    assign pix_x_o   = de_o ? h_idx : '0;
    assign pix_y_o   = de_o ? v_idx : '0;

    // R4: inside the data window both syncs are at their inactive level
    assert_window_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> (hsync_o == !st_q.shd.hs_high) && (vsync_o == !st_q.shd.vs_high));

    // R5: request strobe lasts a single controller clock
    assert_req_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req_o |=> !pix_req_o);

    // R10: dropping the enable silences data and requests on the next clock
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!de_o && !pix_req_o));

endmodule

// File: tb/lcd_timing_gen_tb_top.sv
`timescale 1ns/1ps
module lcd_timing_gen_tb_top;

    localparam int PCD_W = 8;
    localparam int H_W   = 10;
    localparam int V_W   = 10;

    typedef struct packed {
        int pcd; int rise; int hsh; int vsh; int dual;
        int hsw; int hbp; int hact; int hfp;
        int vsw; int vbp; int lines; int vfp;
    } cfg_t;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, en;
    logic [PCD_W-1:0] pcd;
    logic rise, hsh, vsh, dual;
    logic [H_W-1:0] hsw, hbp, hact, hfp;
    logic [V_W-1:0] vsw, vbp, vlines, vfp;
    logic pclk_o, hsync_o, vsync_o, de_o, pix_req_o;
    logic [H_W-1:0] pix_x_o;
    logic [V_W-1:0] pix_y_o;

    lcd_timing_gen #(.PCD_W(PCD_W), .H_W(H_W), .V_W(V_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .cfg_pcd_i(pcd),
        .cfg_launch_rise_i(rise), .cfg_hs_high_i(hsh), .cfg_vs_high_i(vsh),
        .cfg_dual_i(dual), .cfg_hsw_i(hsw), .cfg_hbp_i(hbp), .cfg_hact_i(hact),
        .cfg_hfp_i(hfp), .cfg_vsw_i(vsw), .cfg_vbp_i(vbp), .cfg_vlines_i(vlines),
        .cfg_vfp_i(vfp), .pclk_o(pclk_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .de_o(de_o), .pix_req_o(pix_req_o), .pix_x_o(pix_x_o), .pix_y_o(pix_y_o)
    );

    int checks = 0;
    int bad    = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            bad  = bad + 1;
            $display("FAIL R10 watchdog expired actual=%0d expected<150000", cyc);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic apply(input cfg_t c);
        pcd = c.pcd[PCD_W-1:0]; rise = c.rise[0]; hsh = c.hsh[0]; vsh = c.vsh[0];
        dual = c.dual[0];
        hsw = c.hsw[H_W-1:0]; hbp = c.hbp[H_W-1:0]; hact = c.hact[H_W-1:0]; hfp = c.hfp[H_W-1:0];
        vsw = c.vsw[V_W-1:0]; vbp = c.vbp[V_W-1:0]; vlines = c.lines[V_W-1:0]; vfp = c.vfp[V_W-1:0];
    endtask

    function automatic int act_lines(input cfg_t c);
        return (c.dual != 0) ? c.lines / 2 : c.lines;
    endfunction

    function automatic int line_len(input cfg_t c);
        return c.hsw + c.hbp + c.hact + c.hfp;
    endfunction

    function automatic int frame_len(input cfg_t c);
        return line_len(c) * (c.vsw + c.vbp + act_lines(c) + c.vfp);
    endfunction

    // Compare all outputs against the raster position p of config c
    task automatic check_pos(input cfg_t c, input int p, input string tag);
        int h, v, hlo, vlo;
        bit hs_a, vs_a, ha, va, de_e;
        h    = p % line_len(c);
        v    = p / line_len(c);
        hlo  = c.hsw + c.hbp;
        vlo  = c.vsw + c.vbp;
        hs_a = (h < c.hsw);
        vs_a = (v < c.vsw);
        ha   = (h >= hlo) && (h < hlo + c.hact);
        va   = (v >= vlo) && (v < vlo + act_lines(c));
        de_e = ha && va;
        chk("R2/R6", "hsync", int'(hsync_o), (c.hsh != 0) ? int'(hs_a) : int'(!hs_a));
        chk("R3/R6", "vsync", int'(vsync_o), (c.vsh != 0) ? int'(vs_a) : int'(!vs_a));
        chk(tag, "de", int'(de_o), int'(de_e));
        chk("R4", "pix_x", int'(pix_x_o), de_e ? h - hlo : 0);
        chk("R4", "pix_y", int'(pix_y_o), de_e ? v - vlo : 0);
        chk("R5", "pix_req", int'(pix_req_o), int'(de_e));
    endtask

    task automatic check_idle(input cfg_t c);
        chk("R10", "idle hsync", int'(hsync_o), (c.hsh != 0) ? 0 : 1);
        chk("R10", "idle vsync", int'(vsync_o), (c.vsh != 0) ? 0 : 1);
        chk("R10", "idle de", int'(de_o), 0);
        chk("R10", "idle pix_req", int'(pix_req_o), 0);
        chk("R8", "idle pclk level", int'(pclk_o), c.rise);
    endtask

    task automatic wait_launch(input cfg_t c);
        if (c.rise != 0) @(posedge pclk_o);
        else             @(negedge pclk_o);
        @(negedge clk);
    endtask

    // Run config a; optionally switch to b after sample change_k
    task automatic play(input cfg_t a, input cfg_t b, input int change_k,
                        input int frames_b, input string tag);
        int a_end, total, prev, p;
        bit in_b, prev_b;
        en = 1'b0;
        apply(a);
        repeat (3) @(negedge clk);
        check_idle(a);
        en = 1'b1;
        if (change_k < 0) begin
            a_end = 2 * frame_len(a);
            total = a_end;
        end else begin
            a_end = (change_k / frame_len(a) + 1) * frame_len(a);
            total = a_end + frames_b * frame_len(b);
        end
        prev   = 0;
        prev_b = 1'b0;
        for (int k = 0; k < total; k++) begin
            in_b = (k >= a_end);
            wait_launch(in_b ? b : a);
            p = in_b ? (k - a_end) % frame_len(b) : k % frame_len(a);
            check_pos(in_b ? b : a, p, (change_k >= 0) ? "R9" : tag);
            if (k > 0 && in_b == prev_b)
                chk("R1", "pclk period", cyc - prev, 2 * ((in_b ? b.pcd : a.pcd) + 1));
            prev   = cyc;
            prev_b = in_b;
            if (k == change_k) apply(b);
        end
        // Drop enable mid-line and check the quiet state one clock later
        repeat (3) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check_idle((change_k >= 0) ? b : a);
    endtask

    initial begin
        cfg_t ca, cb, cc, cd, ce, cf;
        ca = '{pcd:0, rise:0, hsh:1, vsh:0, dual:0, hsw:2, hbp:1, hact:4, hfp:2,
               vsw:1, vbp:1, lines:3, vfp:1};
        cb = '{pcd:1, rise:1, hsh:0, vsh:1, dual:0, hsw:1, hbp:0, hact:3, hfp:0,
               vsw:2, vbp:0, lines:4, vfp:0};
        cc = '{pcd:0, rise:0, hsh:1, vsh:1, dual:1, hsw:1, hbp:2, hact:3, hfp:1,
               vsw:1, vbp:1, lines:7, vfp:2};
        cd = '{pcd:2, rise:0, hsh:0, vsh:0, dual:0, hsw:0, hbp:1, hact:2, hfp:1,
               vsw:0, vbp:0, lines:2, vfp:1};
        ce = '{pcd:255, rise:1, hsh:1, vsh:1, dual:0, hsw:1, hbp:0, hact:2, hfp:1,
               vsw:1, vbp:0, lines:2, vfp:0};
        cf = '{pcd:1, rise:0, hsh:0, vsh:1, dual:0, hsw:3, hbp:1, hact:2, hfp:1,
               vsw:1, vbp:2, lines:2, vfp:1};

        rst_n = 1'b0;
        en    = 1'b0;
        apply(ca);
        repeat (4) @(negedge clk);
        // R10: reset state with an all-zero shadow (low-active syncs idle high)
        chk("R10", "reset de", int'(de_o), 0);
        chk("R10", "reset pix_req", int'(pix_req_o), 0);
        chk("R10", "reset pclk", int'(pclk_o), 0);
        chk("R10", "reset hsync", int'(hsync_o), 1);
        rst_n = 1'b1;

        play(ca, ca, -1, 0, "R4");   // basic raster, divide by 2
        play(cb, cb, -1, 0, "R8");   // rising launch, zero porches
        play(cc, cc, -1, 0, "R7");   // dual scan, odd height
        play(cd, cd, -1, 0, "R2");   // zero-length syncs
        play(ce, ce, -1, 0, "R1");   // largest divider
        play(ca, cf, 20, 2, "R9");   // mid-frame rewrite

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule